// File: doc/BRIEF.md
# Fetch Next-PC Predictor

This block sits beside the instruction fetch stage and guesses where fetch goes next. Each cycle it takes the current fetch address and looks at both 32-bit instruction slots of the aligned 8-byte packet that holds it. If the fetch address points at the upper half of the packet, only the upper slot is considered. For every live slot it reads a tagged target table and a table of two-bit direction counters. The first slot whose entry says "jump" or "conditional and likely taken" supplies the predicted next address. Otherwise fetch falls through to the next packet.

Resolved branches train the tables. Only conditional branches and direct jumps enter the target table. Indirect jumps and other instructions are ignored. A conditional branch that misses in the target table is not taken here; a later stage can force a redirect through a hint input, and the hint wins over any table result. A separate eight-deep return-address stack accepts push (call) and pop (return) requests and always shows its top entry with a validity flag. All lookups are combinational from registered state, so an update in the same cycle as a lookup becomes visible one cycle later.

Top module: `fetch_predictor`

## Requirements
- R1: After reset, no lookup predicts taken, `pred_slot` is 0, the next address is the following packet, and `ret_valid` is 0.
- R2: A packet is the 8-byte aligned block containing `fetch_pc`; slot 0 is at offset 0 and slot 1 at offset 4. When `fetch_pc[2]` is 1, slot 0 is skipped. With no taken slot, `pred_next_pc` equals the packet base plus 8.
- R3: A target entry is selected by address bits [9:2] and holds an 8-bit tag from bits [17:10]; a tag mismatch is a miss. A hit on a jump entry is always taken. A hit on a conditional entry is taken only if that slot's direction counter is 2 or 3.
- R4: Update kind encoding on `upd_kind`: 0 conditional, 1 direct jump, 2 indirect jump, 3 other. Kinds 2 and 3 change no table state.
- R5: Direction counters are indexed by address bits [11:2]. They reset to 1, step up on taken and down on not-taken, and saturate at 0 and 3. Only conditional updates move them. A taken conditional writes its target entry; a not-taken one does not.
- R6: When both live slots would be taken, slot 0 wins; `pred_slot` reports the winning slot.
- R7: While `redir_valid` is 1, `pred_taken` is 1, `pred_next_pc` equals `redir_target` and `pred_slot` is 0.
- R8: The return stack is last-in first-out. `ret_target` shows the most recently pushed address not yet popped, and `ret_valid` is 1 while the stack holds any entry.
- R9: A push onto a full stack (8 entries) drops the oldest entry. A pop from an empty stack changes nothing and leaves `ret_valid` at 0.
- R10: A push and a pop in the same cycle on a non-empty stack replace the top entry; on an empty stack they act as a push.
- R11: An update in the same cycle as a lookup of the same entry does not affect that cycle's prediction; it shows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Current fetch address |
| redir_valid | input | 1 | Late-stage redirect hint for a taken branch that missed |
| redir_target | input | 32 | Address supplied with the hint |
| upd_valid | input | 1 | A resolved branch trains the tables this cycle |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_kind | input | 2 | Kind of the resolved instruction (R4 encoding) |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target address |
| call_push | input | 1 | Push `call_addr` onto the return stack |
| call_addr | input | 32 | Return address to push |
| ret_pop | input | 1 | Pop the return stack |
| pred_taken | output | 1 | Prediction leaves sequential fetch |
| pred_slot | output | 1 | Slot that produced a table-based taken prediction |
| pred_next_pc | output | 32 | Predicted next fetch address |
| ret_valid | output | 1 | Return stack holds an entry |
| ret_target | output | 32 | Top entry of the return stack |

## Verification
Three collisions get direct attention. The first is an update and a lookup that hit the same table entry in one cycle. The bench trains a jump or conditional at the very address it is fetching and expects the old prediction in that cycle and the new one in the next. The second is a push and a pop in the same cycle, driven both with an empty stack and with a filled one; the judgement is the visible top and validity after the edge. The third is a redirect hint against a packet whose tables already predict taken, where the hint must win. A random phase then mixes all three with random training over a small aliasing address range, and a behavioural model is compared against the outputs every cycle.

// File: rtl/pred_pkg.sv
package pred_pkg;

   // kind of a resolved instruction, as driven on the update port
   typedef enum logic [1:0] {
      UPK_COND  = 2'd0,
      UPK_JUMP  = 2'd1,
      UPK_IND   = 2'd2,
      UPK_OTHER = 2'd3
   } upd_kind_e;

   // two-bit state kept in each target entry
   typedef enum logic [1:0] {
      TGT_EMPTY = 2'd0,
      TGT_COND  = 2'd1,
      TGT_JUMP  = 2'd2,
      TGT_SPARE = 2'd3
   } tgt_state_e;

endpackage

// File: rtl/target_table.sv
module target_table
   import pred_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 256,
   parameter int TAG_W  = 8,
   parameter int NRD    = 2,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NRD-1:0][IDX_W-1:0]     rd_idx,
   input  logic [NRD-1:0][TAG_W-1:0]     rd_tag,
   output logic [NRD-1:0]                rd_hit,
   output tgt_state_e [NRD-1:0]          rd_state,
   output logic [NRD-1:0][ADDR_W-1:0]    rd_target,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [TAG_W-1:0]              wr_tag,
   input  tgt_state_e                    wr_state,
   input  logic [ADDR_W-1:0]             wr_target
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("target_table: DEPTH must be a power of two");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("target_table: NRD must be at least 1");
   end

   tgt_state_e              state_q [DEPTH];
   logic [TAG_W-1:0]        tag_q   [DEPTH];
   logic [ADDR_W-1:0]       tgt_q   [DEPTH];

   // state carries the reset; tag and target are qualified by it
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) state_q[i] <= TGT_EMPTY;
      end else if (wr_en) begin
         state_q[wr_idx] <= wr_state;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_target;
      end
   end

   // combinational read ports: a same-cycle write is seen next cycle
   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin
         rd_state[p]  = state_q[rd_idx[p]];
         rd_target[p] = tgt_q[rd_idx[p]];
         rd_hit[p]    = (state_q[rd_idx[p]] != TGT_EMPTY) &&
                        (tag_q[rd_idx[p]] == rd_tag[p]);
      end
   end

   AST_TGT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (state_q[$past(wr_idx)] == $past(wr_state)) &&
                (tgt_q[$past(wr_idx)] == $past(wr_target))); // R3

endmodule

// File: rtl/direction_table.sv
module direction_table #(
   parameter int DEPTH     = 1024,
   parameter int CTR_W     = 2,
   parameter int RESET_VAL = 1,
   parameter int NRD       = 2,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}},
   localparam logic [CTR_W-1:0] CTR_RST = CTR_W'(RESET_VAL)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
   output logic [NRD-1:0]             rd_taken,
   input  logic                       up_en,
   input  logic [IDX_W-1:0]           up_idx,
   input  logic                       up_taken
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("direction_table: DEPTH must be a power of two");
   end
   if (CTR_W < 1 || RESET_VAL < 0 || RESET_VAL >= (1 << CTR_W)) begin : g_bad_ctr
      $error("direction_table: RESET_VAL out of counter range");
   end

   logic [CTR_W-1:0] ctr_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RST;
      end else if (up_en) begin
         if (up_taken && ctr_q[up_idx] != CTR_MAX)
            ctr_q[up_idx] <= ctr_q[up_idx] + 1'b1;
         else if (!up_taken && ctr_q[up_idx] != '0)
            ctr_q[up_idx] <= ctr_q[up_idx] - 1'b1;
      end
   end

   // taken when the counter is in its upper half
   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_taken[p] = ctr_q[rd_idx[p]][CTR_W-1];
   end

   AST_CTR_NO_DROP_ON_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && up_taken) |=> ctr_q[$past(up_idx)] >= $past(ctr_q[up_idx])); // R5

   AST_CTR_NO_RISE_ON_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && !up_taken) |=> ctr_q[$past(up_idx)] <= $past(ctr_q[up_idx])); // R5

endmodule

// File: rtl/return_stack.sv
module return_stack #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              pop,
   output logic              top_valid,
   output logic [ADDR_W-1:0] top_addr
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("return_stack: DEPTH must be a power of two");
   end

   logic [ADDR_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]  top_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              nonempty;

   assign nonempty = (cnt_q != '0);

   // circular store: the pointer wraps, so a full push lands on the oldest slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_q <= '0;
         cnt_q <= '0;
      end else if (push && pop && nonempty) begin
         slot_q[top_q] <= push_addr;
      end else if (push) begin
         top_q <= top_q + 1'b1;
         slot_q[top_q + 1'b1] <= push_addr;
         if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end else if (pop && nonempty) begin
         top_q <= top_q - 1'b1;
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign top_valid = nonempty;
   assign top_addr  = slot_q[top_q];

   AST_RAS_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL); // R9

   AST_RAS_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> top_valid && (top_addr == $past(push_addr))); // R8

   AST_RAS_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !top_valid) |=> !top_valid); // R9

   AST_RAS_SWAP_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && top_valid) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/fetch_predictor.sv
module fetch_predictor
   import pred_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int TGT_DEPTH = 256,
   parameter int TAG_W     = 8,
   parameter int DIR_DEPTH = 1024,
   parameter int DIR_CTR_W = 2,
   parameter int RAS_DEPTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   input  logic            redir_valid,
   input  logic [PC_W-1:0] redir_target,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic [1:0]      upd_kind,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   input  logic            call_push,
   input  logic [PC_W-1:0] call_addr,
   input  logic            ret_pop,
   output logic            pred_taken,
   output logic            pred_slot,
   output logic [PC_W-1:0] pred_next_pc,
   output logic            ret_valid,
   output logic [PC_W-1:0] ret_target
);

   localparam int NSLOT   = 2;
   localparam int TGT_IW  = $clog2(TGT_DEPTH);
   localparam int DIR_IW  = $clog2(DIR_DEPTH);
   localparam int TAG_LO  = TGT_IW + 2;
   localparam int TAG_HI  = TAG_LO + TAG_W - 1;
   localparam int PKT_LSB = 3;

   if (TAG_HI >= PC_W || DIR_IW + 1 >= PC_W) begin : g_bad_width
      $error("fetch_predictor: PC_W too narrow for index and tag fields");
   end
   if (TGT_IW < 2 || DIR_IW < 2) begin : g_bad_tables
      $error("fetch_predictor: tables need at least four entries");
   end

   // ---------------- lookup side ----------------
   logic [NSLOT-1:0][TGT_IW-1:0] lk_tidx;
   logic [NSLOT-1:0][TAG_W-1:0]  lk_tag;
   logic [NSLOT-1:0][DIR_IW-1:0] lk_didx;
   logic [NSLOT-1:0]             lk_hit;
   tgt_state_e [NSLOT-1:0]       lk_state;
   logic [NSLOT-1:0][PC_W-1:0]   lk_target;
   logic [NSLOT-1:0]             lk_dir;
   logic [NSLOT-1:0]             slot_live;
   logic [NSLOT-1:0]             slot_take;
   logic [PC_W-1:0]              seq_pc;

   // slot s sits at packet base + 4*s; bit 2 of its address is s
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign lk_tidx[s]   = {fetch_pc[TGT_IW+1:PKT_LSB], 1'(s)};
      assign lk_didx[s]   = {fetch_pc[DIR_IW+1:PKT_LSB], 1'(s)};
      assign lk_tag[s]    = fetch_pc[TAG_HI:TAG_LO];
      assign slot_live[s] = (s != 0) || !fetch_pc[2];
      assign slot_take[s] = slot_live[s] && lk_hit[s] &&
                            ((lk_state[s] == TGT_JUMP) ||
                             ((lk_state[s] == TGT_COND) && lk_dir[s]));
   end

   assign seq_pc = {fetch_pc[PC_W-1:PKT_LSB] + 1'b1, {PKT_LSB{1'b0}}};

   always_comb begin
      pred_taken   = 1'b0;
      pred_slot    = 1'b0;
      pred_next_pc = seq_pc;
      if (redir_valid) begin
         pred_taken   = 1'b1;
         pred_next_pc = redir_target;
      end else if (slot_take[0]) begin
         pred_taken   = 1'b1;
         pred_next_pc = lk_target[0];
      end else if (slot_take[1]) begin
         pred_taken   = 1'b1;
         pred_slot    = 1'b1;
         pred_next_pc = lk_target[1];
      end
   end

   // ---------------- training side ----------------
   upd_kind_e  up_kind;
   logic       tgt_wr_en;
   tgt_state_e tgt_wr_state;
   logic       dir_up_en;

   assign up_kind      = upd_kind_e'(upd_kind);
   assign tgt_wr_en    = upd_valid &&
                         ((up_kind == UPK_JUMP) || ((up_kind == UPK_COND) && upd_taken));
   assign tgt_wr_state = (up_kind == UPK_JUMP) ? TGT_JUMP : TGT_COND;
   assign dir_up_en    = upd_valid && (up_kind == UPK_COND);

   target_table #(
      .ADDR_W (PC_W),
      .DEPTH  (TGT_DEPTH),
      .TAG_W  (TAG_W),
      .NRD    (NSLOT)
   ) i_target_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (lk_tidx),
      .rd_tag    (lk_tag),
      .rd_hit    (lk_hit),
      .rd_state  (lk_state),
      .rd_target (lk_target),
      .wr_en     (tgt_wr_en),
      .wr_idx    (upd_pc[TGT_IW+1:2]),
      .wr_tag    (upd_pc[TAG_HI:TAG_LO]),
      .wr_state  (tgt_wr_state),
      .wr_target (upd_target)
   );

   direction_table #(
      .DEPTH     (DIR_DEPTH),
      .CTR_W     (DIR_CTR_W),
      .RESET_VAL (1),
      .NRD       (NSLOT)
   ) i_direction_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_didx),
      .rd_taken (lk_dir),
      .up_en    (dir_up_en),
      .up_idx   (upd_pc[DIR_IW+1:2]),
      .up_taken (upd_taken)
   );

   return_stack #(
      .ADDR_W (PC_W),
      .DEPTH  (RAS_DEPTH)
   ) i_return_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (call_push),
      .push_addr (call_addr),
      .pop       (ret_pop),
      .top_valid (ret_valid),
      .top_addr  (ret_target)
   );

   // address bits that select nothing in either table
   logic unused_addr_bits;
   assign unused_addr_bits = ^{fetch_pc[1:0], upd_pc[1:0], upd_pc[PC_W-1:TAG_HI+1],
                               fetch_pc[PC_W-1:TAG_HI+1]};

   // ---------------- assertions ----------------
   AST_FALLTHRU_NEXT_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (pred_next_pc[PKT_LSB-1:0] == '0) &&
                      (pred_next_pc[PC_W-1:PKT_LSB] == fetch_pc[PC_W-1:PKT_LSB] + 1'b1)); // R2

   AST_HINT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> pred_taken && !pred_slot && (pred_next_pc == redir_target)); // R7

   AST_UPPER_HALF_SKIPS_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_taken && !redir_valid && fetch_pc[2]) |-> pred_slot); // R6

   AST_IGNORED_KIND_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_kind[1]) |-> !tgt_wr_en && !dir_up_en); // R4

endmodule

// File: tb/test_fetch_predictor.sv
module test_fetch_predictor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        redir_valid = 1'b0;
   logic [31:0] redir_target = '0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic [1:0]  upd_kind = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;
   logic        call_push = 1'b0;
   logic [31:0] call_addr = '0;
   logic        ret_pop = 1'b0;
   logic        pred_taken;
   logic        pred_slot;
   logic [31:0] pred_next_pc;
   logic        ret_valid;
   logic [31:0] ret_target;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk; // 50 MHz

   fetch_predictor i_fetch_predictor (
      .clk          (clk),
      .rst_n        (rst_n),
      .fetch_pc     (fetch_pc),
      .redir_valid  (redir_valid),
      .redir_target (redir_target),
      .upd_valid    (upd_valid),
      .upd_pc       (upd_pc),
      .upd_kind     (upd_kind),
      .upd_taken    (upd_taken),
      .upd_target   (upd_target),
      .call_push    (call_push),
      .call_addr    (call_addr),
      .ret_pop      (ret_pop),
      .pred_taken   (pred_taken),
      .pred_slot    (pred_slot),
      .pred_next_pc (pred_next_pc),
      .ret_valid    (ret_valid),
      .ret_target   (ret_target)
   );

   // ---------------- behavioural reference ----------------
   int          m_state [256];   // 0 empty, 1 conditional, 2 jump
   int          m_tag   [256];
   int unsigned m_tgt   [256];
   int          m_dir   [1024];
   int unsigned m_stack [$];

   task automatic model_reset();
      for (int i = 0; i < 256; i++) m_state[i] = 0;
      for (int i = 0; i < 1024; i++) m_dir[i] = 1;
      m_stack.delete();
   endtask

   task automatic model_lookup(input logic [31:0] pc, output bit tk, output bit sl,
                               output logic [31:0] nx);
      int unsigned base;
      base = {pc[31:3], 3'b000};
      tk = 0; sl = 0; nx = base + 8;
      for (int s = 0; s < 2; s++) begin
         int unsigned spc;
         int bi;
         bit take;
         spc = base + 4 * s;
         bi  = (spc >> 2) & 255;
         take = 0;
         if (s == 0 && pc[2]) continue;
         if (m_state[bi] != 0 && m_tag[bi] == ((spc >> 10) & 255)) begin
            if (m_state[bi] == 2) take = 1;
            if (m_state[bi] == 1 && m_dir[(spc >> 2) & 1023] >= 2) take = 1;
         end
         if (take && !tk) begin
            tk = 1; sl = s[0]; nx = m_tgt[bi];
         end
      end
      if (redir_valid) begin
         tk = 1; sl = 0; nx = redir_target;
      end
   endtask

   task automatic model_clock();
      if (upd_valid) begin
         int bi;
         int di;
         bi = (upd_pc >> 2) & 255;
         di = (upd_pc >> 2) & 1023;
         if (upd_kind == 2'd0) begin
            if (upd_taken && m_dir[di] < 3) m_dir[di]++;
            if (!upd_taken && m_dir[di] > 0) m_dir[di]--;
         end
         if ((upd_kind == 2'd0 && upd_taken) || upd_kind == 2'd1) begin
            m_state[bi] = (upd_kind == 2'd1) ? 2 : 1;
            m_tag[bi]   = (upd_pc >> 10) & 255;
            m_tgt[bi]   = upd_target;
         end
      end
      if (call_push && ret_pop && m_stack.size() > 0) begin
         m_stack[m_stack.size() - 1] = call_addr;
      end else if (call_push) begin
         if (m_stack.size() == 8) void'(m_stack.pop_front());
         m_stack.push_back(call_addr);
      end else if (ret_pop && m_stack.size() > 0) begin
         void'(m_stack.pop_back());
      end
   endtask

   // one cycle: inputs already set after a falling edge; compare, then clock
   task automatic cyc(input string tag);
      bit          e_tk, e_sl, e_rv;
      logic [31:0] e_nx, e_rt;
      #2;
      model_lookup(fetch_pc, e_tk, e_sl, e_nx);
      e_rv = (m_stack.size() != 0);
      e_rt = e_rv ? m_stack[m_stack.size() - 1] : 32'h0;
      checks++;
      if (pred_taken !== e_tk || pred_slot !== e_sl || pred_next_pc !== e_nx ||
          ret_valid !== e_rv || (e_rv && ret_target !== e_rt)) begin
         errors++;
         $display("FAIL %s pc=%h: got taken=%0b slot=%0b next=%h rvalid=%0b rtop=%h expected taken=%0b slot=%0b next=%h rvalid=%0b rtop=%h",
                  tag, fetch_pc, pred_taken, pred_slot, pred_next_pc, ret_valid, ret_target,
                  e_tk, e_sl, e_nx, e_rv, e_rt);
      end
      @(posedge clk);
      model_clock();
      @(negedge clk);
   endtask

   task automatic idle();
      upd_valid = 0; call_push = 0; ret_pop = 0; redir_valid = 0;
   endtask

   task automatic train(input logic [31:0] pc, input logic [1:0] kind, input bit tk,
                        input logic [31:0] tgt);
      upd_valid = 1; upd_pc = pc; upd_kind = kind; upd_taken = tk; upd_target = tgt;
   endtask

   task automatic look(input logic [31:0] pc, input string tag);
      idle();
      fetch_pc = pc;
      cyc(tag);
   endtask

   initial begin
      #4_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, got hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: clean state
      look(32'h0000_0100, "R1 reset idle");
      look(32'h0000_0104, "R1 reset upper half");
      look(32'h0000_0ffc, "R1 reset packet wrap");

      // R3 jump entry, R2 slot geometry, tag aliasing
      train(32'h0000_0100, 2'd1, 1, 32'h0000_2000); fetch_pc = 32'h0; cyc("R3 train jump");
      look(32'h0000_0100, "R3 jump hit slot0");
      look(32'h0000_0104, "R2 slot0 skipped");
      look(32'h0000_0500, "R3 alias tag miss");

      // R4: indirect and other kinds ignored
      train(32'h0000_0200, 2'd2, 1, 32'h0000_4000); fetch_pc = 32'h0; cyc("R4 indirect train");
      train(32'h0000_0200, 2'd3, 1, 32'h0000_4400); fetch_pc = 32'h0; cyc("R4 other train");
      look(32'h0000_0200, "R4 ignored kinds no hit");

      // R5: direction counter walk at 0x300
      train(32'h0000_0300, 2'd0, 0, 32'h0000_5000); fetch_pc = 32'h300; cyc("R5 not-taken");
      look(32'h0000_0300, "R5 not-taken no entry");
      train(32'h0000_0300, 2'd0, 1, 32'h0000_5000); fetch_pc = 32'h300; cyc("R5 taken 1");
      look(32'h0000_0300, "R5 counter 1 weak");
      train(32'h0000_0300, 2'd0, 1, 32'h0000_5000); fetch_pc = 32'h300; cyc("R5 taken 2");
      look(32'h0000_0300, "R5 counter 2 taken");
      for (int i = 0; i < 3; i++) begin
         train(32'h0000_0300, 2'd0, 1, 32'h0000_5000); fetch_pc = 32'h300; cyc("R5 saturate high");
      end
      train(32'h0000_0300, 2'd0, 0, 32'h0000_5000); fetch_pc = 32'h300; cyc("R5 down from 3");
      look(32'h0000_0300, "R5 still taken at 2");
      train(32'h0000_0300, 2'd0, 0, 32'h0000_5000); fetch_pc = 32'h300; cyc("R5 down to 1");
      look(32'h0000_0300, "R5 not taken at 1");
      for (int i = 0; i < 3; i++) begin
         train(32'h0000_0300, 2'd0, 0, 32'h0000_5000); fetch_pc = 32'h300; cyc("R5 saturate low");
      end
      train(32'h0000_0300, 2'd0, 1, 32'h0000_5000); fetch_pc = 32'h300; cyc("R5 up from 0");
      look(32'h0000_0300, "R5 counter 1 after floor");

      // R6: slot priority
      train(32'h0000_0404, 2'd1, 1, 32'h0000_3000); fetch_pc = 32'h0; cyc("R6 train slot1");
      look(32'h0000_0400, "R6 slot1 only");
      train(32'h0000_0400, 2'd1, 1, 32'h0000_3100); fetch_pc = 32'h0; cyc("R6 train slot0");
      look(32'h0000_0400, "R6 slot0 wins");
      look(32'h0000_0404, "R6 upper half uses slot1");

      // R7: hint override
      idle(); fetch_pc = 32'h400; redir_valid = 1; redir_target = 32'h0000_7770; cyc("R7 hint over hit");
      idle(); fetch_pc = 32'h800; redir_valid = 1; redir_target = 32'h0000_7774; cyc("R7 hint over miss");

      // R11: same-cycle update and lookup
      train(32'h0000_0600, 2'd1, 1, 32'h0000_6000); fetch_pc = 32'h600; cyc("R11 old view same cycle");
      look(32'h0000_0600, "R11 new view next cycle");
      train(32'h0000_0604, 2'd1, 1, 32'h0000_6100); fetch_pc = 32'h600; cyc("R11 jump over old slot1");
      look(32'h0000_0604, "R11 slot1 next cycle");

      // R8: return stack order
      for (int i = 0; i < 3; i++) begin
         idle(); call_push = 1; call_addr = 32'h0000_a000 + 32'(i * 4); cyc("R8 push");
      end
      for (int i = 0; i < 3; i++) begin
         idle(); ret_pop = 1; cyc("R8 pop");
      end
      look(32'h0, "R8 empty after pops");

      // R10: swap on empty and on non-empty
      idle(); call_push = 1; ret_pop = 1; call_addr = 32'h0000_b000; cyc("R10 swap on empty");
      idle(); call_push = 1; call_addr = 32'h0000_b004; cyc("R10 push second");
      idle(); call_push = 1; ret_pop = 1; call_addr = 32'h0000_b008; cyc("R10 swap top");
      idle(); ret_pop = 1; cyc("R10 pop swapped");
      idle(); ret_pop = 1; cyc("R10 pop base");
      look(32'h0, "R10 empty");

      // R9: overflow and empty pop
      for (int i = 0; i < 10; i++) begin
         idle(); call_push = 1; call_addr = 32'h0000_c000 + 32'(i * 4); cyc("R9 overfill");
      end
      for (int i = 0; i < 9; i++) begin
         idle(); ret_pop = 1; cyc("R9 drain");
      end
      idle(); ret_pop = 1; cyc("R9 pop empty");
      look(32'h0, "R9 still empty");

      // mixed random traffic over an aliasing address range
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] rpc;
         idle();
         fetch_pc = {$urandom_range(3, 0) * 32'h400 + $urandom_range(63, 0) * 4};
         if ($urandom_range(3, 0) == 0) begin
            rpc = {$urandom_range(3, 0) * 32'h400 + $urandom_range(63, 0) * 4};
            train(rpc, 2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)), $urandom());
         end
         call_push   = ($urandom_range(3, 0) == 0);
         call_addr   = $urandom();
         ret_pop     = ($urandom_range(3, 0) == 0);
         redir_valid = ($urandom_range(15, 0) == 0);
         redir_target = $urandom();
         cyc("R3 R5 R11 random mix");
      end

      idle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule